// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor front end and the request queue of a cache controller. It records every cache-line request that is still in flight. A request carries a byte address, a kind and a byte length. In the same cycle the block either grants the request and returns a fresh request ID, or refuses it. A refused request leaves no trace in the block.

A granted request is placed in one of two small fully associative tables, both keyed by line address. Stores and both atomic kinds go to the write table. Loads and instruction fetches go to the read table. One cycle after the grant, the request is forwarded downstream as a command class with its line address and ID. A completion names a table and a line. The block frees the matching entry and reports the request ID and the number of cycles the request was outstanding.

While any entry is pending, an age watchdog scans both tables once every threshold period. If the scan finds an entry whose age has reached the threshold, it raises a sticky deadlock flag.

Top module: `mrt_tracker`

## Requirements
- R1: When `pending_count` equals `MAX_PEND`, a valid request is refused: `req_grant` is 0 and `req_refused` is 1.
- R2: A request is refused when its line address (`req_addr[AW-1:OFFW]`) already has a pending entry in either the read table or the write table.
- R3: Kinds 2 (store), 3 (atomic read) and 4 (atomic write) are placed in the write table. Kinds 0 (instruction fetch) and 1 (load) are placed in the read table. A request is refused when its target table has no free entry, even if `pending_count` is below `MAX_PEND`.
- R4: `pending_count` always equals the occupancy of the read table plus the occupancy of the write table. It rises by one for each grant and falls by one for each completion that matches an entry.
- R5: A request is refused when its line offset plus `req_len` exceeds `LINE_BYTES`, or when its kind is above 4. An offset plus length exactly equal to `LINE_BYTES` is accepted.
- R6: One cycle after a grant, `cmd_valid` is 1 and carries the line address, the request ID and a class. The classes are: instruction fetch 0, load 1, store 2, and both atomic kinds 3. With no grant, `cmd_valid` is 0 in the next cycle.
- R7: Granted requests receive consecutive IDs, starting at 0 after reset. A refused request does not consume an ID.
- R8: A completion (`cpl_valid`, with `cpl_is_write` selecting the write table when 1) that matches a pending line frees that entry. One cycle later it raises `done_valid` with the entry's ID and a latency equal to the number of clock edges from grant to completion. A completion that matches nothing in the selected table is ignored: no `done_valid`, and the count is unchanged.
- R9: While entries are pending, a scan runs every `THRESH` cycles. `deadlock` rises when a scan finds an entry whose age is at least `THRESH`. It then stays high until reset. It stays low while every entry completes younger than `THRESH`.
- R10: An entry freed by a completion can be allocated again to the same line from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 fetch, 1 load, 2 store, 3 atomic read, 4 atomic write |
| req_addr | input | AW | Byte address of the request |
| req_len | input | OFFW+1 | Request length in bytes |
| req_grant | output | 1 | Request admitted this cycle |
| req_refused | output | 1 | Request turned away this cycle |
| req_id | output | IDW | ID given to the admitted request |
| cmd_valid | output | 1 | Downstream command present |
| cmd_class | output | 2 | Command class |
| cmd_line | output | LW | Line address of the command |
| cmd_id | output | IDW | ID of the command |
| cpl_valid | input | 1 | Completion present |
| cpl_is_write | input | 1 | Completion targets the write table |
| cpl_line | input | LW | Line address being completed |
| done_valid | output | 1 | Retirement report present |
| done_id | output | IDW | ID of the retired request |
| done_latency | output | TW | Cycles from grant to completion |
| pending_count | output | PCW | Number of entries in flight |
| deadlock | output | 1 | Sticky excessive-age flag |

## Verification
The bench builds the block with four read entries, four write entries and `MAX_PEND` set to 6. With these values the read table fills while the total limit still has room, and the total limit is then reached with writes, so the refusals of R3 and R1 can be told apart. `THRESH` is reduced to 64. Holding a single load for three periods then trips the watchdog within a short run. The busier phases stay well below that age, which keeps the flag low where R9 says it must be low.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam logic [2:0] KIND_FETCH = 3'd0;
  localparam logic [2:0] KIND_LOAD  = 3'd1;
  localparam logic [2:0] KIND_STORE = 3'd2;
  localparam logic [2:0] KIND_ARD   = 3'd3;
  localparam logic [2:0] KIND_AWR   = 3'd4;

  localparam logic [1:0] CLS_FETCH  = 2'd0;
  localparam logic [1:0] CLS_LOAD   = 2'd1;
  localparam logic [1:0] CLS_STORE  = 2'd2;
  localparam logic [1:0] CLS_ATOMIC = 2'd3;

  function automatic logic kind_known(input logic [2:0] k);
    return k <= KIND_AWR;
  endfunction

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k == KIND_STORE) || (k == KIND_ARD) || (k == KIND_AWR);
  endfunction

  function automatic logic [1:0] kind_to_class(input logic [2:0] k);
    case (k)
      KIND_FETCH: return CLS_FETCH;
      KIND_LOAD:  return CLS_LOAD;
      KIND_STORE: return CLS_STORE;
      default:    return CLS_ATOMIC;
    endcase
  endfunction
endpackage

// File: rtl/mrt_table.sv
module mrt_table #(
  parameter int DEPTH  = 4,
  parameter int LW     = 10,
  parameter int IDW    = 8,
  parameter int TW     = 16,
  parameter int THRESH = 256,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LW-1:0]  look_line,
  output logic           look_hit,
  input  logic           alloc_en,
  input  logic [LW-1:0]  alloc_line,
  input  logic [IDW-1:0] alloc_id,
  input  logic [TW-1:0]  alloc_stamp,
  input  logic           free_en,
  input  logic [LW-1:0]  free_line,
  output logic           free_hit,
  output logic [IDW-1:0] free_id,
  output logic [TW-1:0]  free_stamp,
  input  logic [TW-1:0]  now,
  output logic           full,
  output logic [CW-1:0]  count,
  output logic           aged
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [LW-1:0]    line_q  [DEPTH];
  logic [IDW-1:0]   id_q    [DEPTH];
  logic [TW-1:0]    stamp_q [DEPTH];
  logic [IW-1:0]    free_idx, alloc_idx;
  logic             match_any;

  always_comb begin
    look_hit  = 1'b0;
    match_any = 1'b0;
    free_idx  = '0;
    alloc_idx = '0;
    full      = 1'b1;
    count     = '0;
    aged      = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && line_q[i] == look_line) look_hit = 1'b1;
      if (vld_q[i] && line_q[i] == free_line) begin
        match_any = 1'b1;
        free_idx  = IW'(i);
      end
      if (!vld_q[i]) begin
        full      = 1'b0;
        alloc_idx = IW'(i);
      end
      count = count + CW'(vld_q[i]);
      if (vld_q[i] && ((now - stamp_q[i]) >= TW'(THRESH))) aged = 1'b1;
    end
  end

  assign free_hit   = free_en && match_any;
  assign free_id    = id_q[free_idx];
  assign free_stamp = stamp_q[free_idx];

  always_comb begin
    vld_d = vld_q;
    if (free_hit) vld_d[free_idx] = 1'b0;
    if (alloc_en) vld_d[alloc_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      line_q[alloc_idx]  <= alloc_line;
      id_q[alloc_idx]    <= alloc_id;
      stamp_q[alloc_idx] <= alloc_stamp;
    end
  end
endmodule

// File: rtl/mrt_watchdog.sv
module mrt_watchdog #(
  parameter int THRESH = 256,
  localparam int SW    = (THRESH > 2) ? $clog2(THRESH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic aged_any,
  output logic deadlock
);
  logic [SW-1:0] scan_q, scan_d;
  logic          dl_q, dl_d, scan_now;

  assign scan_now = active && (scan_q == SW'(THRESH - 1));

  always_comb begin
    scan_d = scan_q;
    dl_d   = dl_q;
    if (!active)       scan_d = '0;
    else if (scan_now) scan_d = '0;
    else               scan_d = scan_q + SW'(1);
    if (scan_now && aged_any) dl_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
      dl_q   <= 1'b0;
    end else begin
      scan_q <= scan_d;
      dl_q   <= dl_d;
    end
  end

  assign deadlock = dl_q;
endmodule

// File: rtl/mrt_issue.sv
module mrt_issue #(
  parameter int LW  = 10,
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grant,
  input  logic [2:0]     kind,
  input  logic [LW-1:0]  line,
  input  logic [IDW-1:0] id,
  output logic           cmd_valid,
  output logic [1:0]     cmd_class,
  output logic [LW-1:0]  cmd_line,
  output logic [IDW-1:0] cmd_id
);
  import mrt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_valid <= 1'b0;
    else        cmd_valid <= grant;
  end

  always_ff @(posedge clk) begin
    if (grant) begin
      cmd_class <= kind_to_class(kind);
      cmd_line  <= line;
      cmd_id    <= id;
    end
  end
endmodule

// File: rtl/mrt_tracker.sv
module mrt_tracker #(
  parameter int AW         = 16,
  parameter int LINE_BYTES = 64,
  parameter int IDW        = 8,
  parameter int TW         = 16,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int MAX_PEND   = 6,
  parameter int THRESH     = 256,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int LW        = AW - OFFW,
  localparam int PCW       = $clog2(MAX_PEND + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [2:0]     req_kind,
  input  logic [AW-1:0]  req_addr,
  input  logic [OFFW:0]  req_len,
  output logic           req_grant,
  output logic           req_refused,
  output logic [IDW-1:0] req_id,
  output logic           cmd_valid,
  output logic [1:0]     cmd_class,
  output logic [LW-1:0]  cmd_line,
  output logic [IDW-1:0] cmd_id,
  input  logic           cpl_valid,
  input  logic           cpl_is_write,
  input  logic [LW-1:0]  cpl_line,
  output logic           done_valid,
  output logic [IDW-1:0] done_id,
  output logic [TW-1:0]  done_latency,
  output logic [PCW-1:0] pending_count,
  output logic           deadlock
);
  import mrt_pkg::*;

  localparam int RCW = $clog2(RD_DEPTH + 1);
  localparam int WCW = $clog2(WR_DEPTH + 1);

  logic [LW-1:0]    req_line;
  logic [OFFW+1:0]  span;
  logic             is_wr, fits, dup, tgt_full, room, freed;
  logic             rd_hit, wr_hit, rd_full, wr_full, rd_fhit, wr_fhit, rd_aged, wr_aged;
  logic [IDW-1:0]   rd_fid, wr_fid;
  logic [TW-1:0]    rd_fstamp, wr_fstamp;
  logic [RCW-1:0]   rd_cnt;
  logic [WCW-1:0]   wr_cnt;
  logic [TW-1:0]    now_q;
  logic [IDW-1:0]   id_q, id_d;
  logic [PCW-1:0]   pend_q, pend_d;
  logic             done_v_q;

  assign req_line = req_addr[AW-1:OFFW];
  assign span     = (OFFW+2)'(req_addr[OFFW-1:0]) + (OFFW+2)'(req_len);
  assign fits     = span <= (OFFW+2)'(LINE_BYTES);
  assign is_wr    = kind_is_write(req_kind);
  assign dup      = rd_hit || wr_hit;
  assign tgt_full = is_wr ? wr_full : rd_full;
  assign room     = pend_q < PCW'(MAX_PEND);

  assign req_grant   = req_valid && kind_known(req_kind) && fits && !dup && !tgt_full && room;
  assign req_refused = req_valid && !req_grant;
  assign req_id      = id_q;
  assign freed       = rd_fhit || wr_fhit;

  mrt_table #(.DEPTH(RD_DEPTH), .LW(LW), .IDW(IDW), .TW(TW), .THRESH(THRESH)) u_rd_tbl (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(rd_hit),
    .alloc_en(req_grant && !is_wr), .alloc_line(req_line), .alloc_id(id_q), .alloc_stamp(now_q),
    .free_en(cpl_valid && !cpl_is_write), .free_line(cpl_line),
    .free_hit(rd_fhit), .free_id(rd_fid), .free_stamp(rd_fstamp),
    .now(now_q), .full(rd_full), .count(rd_cnt), .aged(rd_aged)
  );

  mrt_table #(.DEPTH(WR_DEPTH), .LW(LW), .IDW(IDW), .TW(TW), .THRESH(THRESH)) u_wr_tbl (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(wr_hit),
    .alloc_en(req_grant && is_wr), .alloc_line(req_line), .alloc_id(id_q), .alloc_stamp(now_q),
    .free_en(cpl_valid && cpl_is_write), .free_line(cpl_line),
    .free_hit(wr_fhit), .free_id(wr_fid), .free_stamp(wr_fstamp),
    .now(now_q), .full(wr_full), .count(wr_cnt), .aged(wr_aged)
  );

  mrt_issue #(.LW(LW), .IDW(IDW)) u_issue (
    .clk(clk), .rst_n(rst_n), .grant(req_grant), .kind(req_kind), .line(req_line), .id(id_q),
    .cmd_valid(cmd_valid), .cmd_class(cmd_class), .cmd_line(cmd_line), .cmd_id(cmd_id)
  );

  mrt_watchdog #(.THRESH(THRESH)) u_wdog (
    .clk(clk), .rst_n(rst_n), .active(pend_q != '0),
    .aged_any(rd_aged || wr_aged), .deadlock(deadlock)
  );

  always_comb begin
    id_d   = req_grant ? id_q + IDW'(1) : id_q;
    pend_d = pend_q + PCW'(req_grant) - PCW'(freed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q    <= '0;
      id_q     <= '0;
      pend_q   <= '0;
      done_v_q <= 1'b0;
    end else begin
      now_q    <= now_q + TW'(1);
      id_q     <= id_d;
      pend_q   <= pend_d;
      done_v_q <= freed;
    end
  end

  always_ff @(posedge clk) begin
    if (freed) begin
      done_id      <= wr_fhit ? wr_fid : rd_fid;
      done_latency <= now_q - (wr_fhit ? wr_fstamp : rd_fstamp);
    end
  end

  assign done_valid    = done_v_q;
  assign pending_count = pend_q;
endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
  parameter int MAX_PEND = 6,
  parameter int RD_DEPTH = 4,
  parameter int WR_DEPTH = 4,
  localparam int PCW     = $clog2(MAX_PEND + 1),
  localparam int RCW     = $clog2(RD_DEPTH + 1),
  localparam int WCW     = $clog2(WR_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_grant,
  input logic           cmd_valid,
  input logic           cpl_valid,
  input logic           done_valid,
  input logic           deadlock,
  input logic [PCW-1:0] pend,
  input logic [RCW-1:0] rd_cnt,
  input logic [WCW-1:0] wr_cnt
);
  a_r1_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend) <= MAX_PEND);

  a_r1_refuse_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(pend) == MAX_PEND) |-> !req_grant);

  a_r4_count_sum: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend) == 32'(rd_cnt) + 32'(wr_cnt));

  a_r6_cmd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |=> cmd_valid);

  a_r6_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !req_grant |=> !cmd_valid);

  a_r8_done_after_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid |=> !done_valid);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);
endmodule

bind mrt_tracker mrt_checker #(
  .MAX_PEND(MAX_PEND), .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
  .cmd_valid(cmd_valid), .cpl_valid(cpl_valid), .done_valid(done_valid),
  .deadlock(deadlock), .pend(pend_q), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt)
);

// File: tb/mrt_tracker_bench.sv
module mrt_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int THR = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, cpl_valid, cpl_is_write;
  logic [2:0] req_kind;
  logic [15:0] req_addr;
  logic [6:0] req_len;
  logic [9:0] cpl_line;
  logic req_grant, req_refused, cmd_valid, done_valid, deadlock;
  logic [7:0] req_id, cmd_id, done_id;
  logic [1:0] cmd_class;
  logic [9:0] cmd_line;
  logic [15:0] done_latency;
  logic [2:0] pending_count;

  int checks = 0;
  int fails = 0;
  int exp_id = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrt_tracker #(.THRESH(THR)) u_mrt_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .req_grant(req_grant),
    .req_refused(req_refused), .req_id(req_id), .cmd_valid(cmd_valid),
    .cmd_class(cmd_class), .cmd_line(cmd_line), .cmd_id(cmd_id),
    .cpl_valid(cpl_valid), .cpl_is_write(cpl_is_write), .cpl_line(cpl_line),
    .done_valid(done_valid), .done_id(done_id), .done_latency(done_latency),
    .pending_count(pending_count), .deadlock(deadlock)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [6:0]  len;
    logic        grant;
    logic        wr;
    logic [1:0]  cls;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{3'd0, 16'h0040, 7'd4,  1'b1, 1'b0, 2'd0},
    '{3'd1, 16'h0080, 7'd8,  1'b1, 1'b0, 2'd1},
    '{3'd2, 16'h00C0, 7'd64, 1'b1, 1'b1, 2'd2},
    '{3'd3, 16'h0100, 7'd8,  1'b1, 1'b1, 2'd3},
    '{3'd4, 16'h0140, 7'd8,  1'b1, 1'b1, 2'd3},
    '{3'd5, 16'h0180, 7'd4,  1'b0, 1'b0, 2'd0},
    '{3'd1, 16'h01FC, 7'd8,  1'b0, 1'b0, 2'd0},
    '{3'd1, 16'h01FC, 7'd4,  1'b1, 1'b0, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Enters and leaves at a falling edge.
  task automatic req(input string tag, input logic [2:0] k, input logic [15:0] a,
                     input logic [6:0] l, input logic exp_g);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = l;
    #1;
    chk({tag, " grant"}, 32'(req_grant), 32'(exp_g));
    chk({tag, " refused"}, 32'(req_refused), 32'(!exp_g));
    if (exp_g) chk({tag, " R7 id"}, 32'(req_id), 32'(exp_id[7:0]));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R6 cmd_valid"}, 32'(cmd_valid), 32'(exp_g));
    if (exp_g) begin
      chk({tag, " R6 cmd_line"}, 32'(cmd_line), 32'(a[15:6]));
      chk({tag, " R6 cmd_id"}, 32'(cmd_id), 32'(exp_id[7:0]));
      exp_id++;
    end
  endtask

  task automatic cpl(input logic wr, input logic [9:0] line);
    cpl_valid = 1'b1; cpl_is_write = wr; cpl_line = line;
    @(posedge clk);
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0; cpl_is_write = 1'b0;
    req_kind = '0; req_addr = '0; req_len = '0; cpl_line = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R4 reset pending", 32'(pending_count), 0);
    chk("R6 reset cmd_valid", 32'(cmd_valid), 0);
    chk("R8 reset done_valid", 32'(done_valid), 0);
    chk("R9 reset deadlock", 32'(deadlock), 0);

    // Vector walk: R3 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      int id_here;
      id_here = exp_id;
      req($sformatf("R5 vec%0d", i), VEC[i].kind, VEC[i].addr, VEC[i].len, VEC[i].grant);
      if (VEC[i].grant) begin
        chk($sformatf("R6 vec%0d class", i), 32'(cmd_class), 32'(VEC[i].cls));
        chk($sformatf("R4 vec%0d pending", i), 32'(pending_count), 1);
        cpl(VEC[i].wr, VEC[i].addr[15:6]);
        chk($sformatf("R3 vec%0d done_valid", i), 32'(done_valid), 1);
        chk($sformatf("R8 vec%0d done_id", i), 32'(done_id), 32'(id_here));
        chk($sformatf("R8 vec%0d latency", i), 32'(done_latency), 1);
        chk($sformatf("R4 vec%0d drained", i), 32'(pending_count), 0);
      end
    end

    // R3 read table fills before the total limit
    for (int i = 0; i < 4; i++) req("R3 fill read", 3'd1, 16'((16 + i) << 6), 7'd4, 1'b1);
    req("R3 read table full", 3'd1, 16'(20 << 6), 7'd4, 1'b0);
    chk("R4 pending four", 32'(pending_count), 4);
    req("R3 store room", 3'd2, 16'(32 << 6), 7'd4, 1'b1);
    req("R3 atomic room", 3'd3, 16'(33 << 6), 7'd4, 1'b1);
    chk("R4 pending six", 32'(pending_count), 6);
    req("R1 limit reached", 3'd2, 16'(34 << 6), 7'd4, 1'b0);

    // R2 duplicates across tables, with room available
    cpl(1'b0, 10'd19);
    chk("R4 pending after free", 32'(pending_count), 5);
    req("R2 load on write line", 3'd1, 16'(32 << 6), 7'd4, 1'b0);
    req("R2 store on read line", 3'd2, 16'(16 << 6) + 16'd8, 7'd4, 1'b0);
    req("R2 fresh store", 3'd2, 16'(34 << 6), 7'd4, 1'b1);

    // R8 completion to the wrong table is ignored
    cpl(1'b1, 10'd16);
    chk("R8 wrong table no done", 32'(done_valid), 0);
    chk("R8 wrong table pending", 32'(pending_count), 6);
    for (int i = 0; i < 3; i++) cpl(1'b0, 10'(16 + i));
    for (int i = 0; i < 3; i++) cpl(1'b1, 10'(32 + i));
    chk("R4 all drained", 32'(pending_count), 0);

    // R10 freed entry reusable next cycle; R8 latency with idle cycles
    req("R10 first", 3'd1, 16'(48 << 6), 7'd4, 1'b1);
    cpl(1'b0, 10'd48);
    req("R10 reuse", 3'd1, 16'(48 << 6), 7'd4, 1'b1);
    idle(5);
    cpl(1'b0, 10'd48);
    chk("R8 latency six", 32'(done_latency), 6);
    chk("R8 latency id", 32'(done_id), 32'(exp_id - 1));
    chk("R9 young entries no deadlock", 32'(deadlock), 0);

    // R9 aged entry trips the watchdog, flag is sticky
    req("R9 hold", 3'd1, 16'(64 << 6), 7'd4, 1'b1);
    idle(3 * THR);
    chk("R9 deadlock raised", 32'(deadlock), 1);
    cpl(1'b0, 10'd64);
    idle(2);
    chk("R9 deadlock sticky", 32'(deadlock), 1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R9 cleared by reset", 32'(deadlock), 0);
    chk("R4 pending after reset", 32'(pending_count), 0);
    exp_id = 0;
    req("R7 id restarts", 3'd0, 16'h0400, 7'd4, 1'b1);

    finished = 1;
    summary();
    $finish;
  end
endmodule